// File: doc/BRIEF.md
# UART Hardware Handshake Controller

This block sits between a UART's transmit and receive FIFOs and its serial shifters and runs the RTS/CTS handshake with no processor involvement. On the transmit side it issues a one-cycle start grant for each character. It grants only when the shifter is idle and the transmit FIFO holds data. When handshaking is on, the grant also waits for the remote clear-to-send. A character that is already shifting always runs to its end, so a withdrawn clear-to-send takes effect only at a character boundary.

On the receive side it drives its own request-to-send line from the receive FIFO occupancy. It withdraws the request once the occupancy reaches a programmable threshold, and it raises the request again when the occupancy falls back under that threshold. One configuration bit sets the active level of both handshake pins. The block also turns the self-clearing flush bits into single-cycle flush pulses, one for each FIFO. When the UART is switched off, it flushes both FIFOs.

Top module: `uart_flow_ctrl`

## Requirements
- R1: With handshaking disabled (`cfg_hs_en`=0), `rts_pin` sits at its inactive level and the CTS pin has no influence on grants.
- R2: `cfg_act_low`=0 makes both pins active-high. `cfg_act_low`=1 makes both active-low: asserted is 0 and inactive is 1.
- R3: `tx_start` pulses for one cycle only when the UART is enabled, the shifter is idle, and the transmit FIFO is non-empty. After a pulse, no further pulse comes until `tx_done` has been seen.
- R4: With handshaking on, CTS passes through a two-flop synchronizer. A character already granted still completes when CTS drops. No new grant is issued until CTS is asserted again.
- R5: With handshaking on, `rts_pin` is inactive one cycle after the receive level is at or above `cfg_rts_thr`, and asserted one cycle after it is below. This holds across the full 6-bit range 0 to 63.
- R6: A threshold of 0 keeps `rts_pin` inactive whenever handshaking is on.
- R7: A one-cycle `cfg_tx_flush_set` gives a one-cycle `tx_flush` on the following cycle and nothing on `rx_flush`. `cfg_rx_flush_set` behaves the same way for `rx_flush` alone.
- R8: A falling edge of `cfg_enable` pulses both `tx_flush` and `rx_flush` on the next cycle. While the UART is disabled, no grant is issued and `rts_pin` stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | UART enable |
| cfg_hs_en | input | 1 | Hardware handshake enable |
| cfg_act_low | input | 1 | 1 = both handshake pins active-low |
| cfg_rts_thr | input | THR_W | Receive level at which RTS is withdrawn |
| cfg_tx_flush_set | input | 1 | Write strobe for the transmit flush bit |
| cfg_rx_flush_set | input | 1 | Write strobe for the receive flush bit |
| cts_pin | input | 1 | Remote clear-to-send, asynchronous |
| tx_fifo_level | input | LVL_W | Transmit FIFO occupancy |
| rx_fifo_level | input | LVL_W | Receive FIFO occupancy |
| tx_busy | input | 1 | Transmit shifter is sending a character |
| tx_done | input | 1 | One-cycle end-of-character from the shifter |
| rts_pin | output | 1 | Request-to-send pin |
| tx_start | output | 1 | One-cycle grant to start the next character |
| tx_flush | output | 1 | One-cycle transmit FIFO flush |
| rx_flush | output | 1 | One-cycle receive FIFO flush |

## Verification
The bench builds the block with its defaults: a 64-entry FIFO (7-bit levels), a 6-bit threshold and a two-stage synchronizer. With these values the threshold's end points 0 and 63 can both be reached with real occupancies, including 62 and 63 against the top threshold. A bench shifter model holds each character for ten cycles. That window is long enough to drop CTS in the middle of a character and still let the two-flop synchronizer settle before the character boundary. This shows that the character completes and that the next grant waits for CTS to return.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef enum logic {
    GATE_IDLE   = 1'b0,
    GATE_ACTIVE = 1'b1
  } gate_state_e;

  // Pin level that represents a logical "asserted" state under the polarity bit.
  function automatic logic hs_pin_level(input logic asserted, input logic act_low);
    return act_low ? ~asserted : asserted;
  endfunction

  // Logical "asserted" state carried by a pin level under the polarity bit.
  function automatic logic hs_pin_meaning(input logic pin, input logic act_low);
    return act_low ? ~pin : pin;
  endfunction

endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_pin,
  input  logic act_low,
  output logic cts_active
);
  import uart_fc_pkg::*;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= cts_pin;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], cts_pin};
      end
    end
  endgenerate

  assign cts_active = hs_pin_meaning(chain_q[STAGES-1], act_low);

endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hs_en,
  input  logic cts_active,
  input  logic has_data,
  input  logic tx_busy,
  input  logic tx_done,
  output logic tx_start
);
  import uart_fc_pkg::*;

  gate_state_e state_q;
  logic        clear_to_go;
  logic        go;

  assign clear_to_go = !hs_en || cts_active;
  assign go = enable && (state_q == GATE_IDLE) && has_data && !tx_busy && clear_to_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= GATE_IDLE;
      tx_start <= 1'b0;
    end else begin
      tx_start <= go;
      case (state_q)
        GATE_IDLE:   if (go) state_q <= GATE_ACTIVE;
        GATE_ACTIVE: if (tx_done) state_q <= GATE_IDLE;
        default:     state_q <= GATE_IDLE;
      endcase
    end
  end

  // R3: a grant never repeats on the next cycle
  p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  // R3: a busy shifter is never granted
  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> !tx_start);

  // R4: handshake on with CTS inactive never leads to a grant
  p_cts_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && !cts_active) |=> !tx_start);

  // R8: a disabled UART never grants
  p_disabled_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tx_start);

endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl #(
  parameter int LVL_W = 7,
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hs_en,
  input  logic             act_low,
  input  logic [THR_W-1:0] thr,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rts_pin
);
  import uart_fc_pkg::*;

  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

  function automatic logic room_left(input logic [LVL_W-1:0] lvl, input logic [THR_W-1:0] t);
    return CMP_W'(lvl) < CMP_W'(t);
  endfunction

  logic want_data;
  logic rts_asserted_q;

  assign want_data = enable && hs_en && room_left(rx_level, thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_asserted_q <= 1'b0;
      rts_pin        <= 1'b0;
    end else begin
      rts_asserted_q <= want_data;
      rts_pin        <= hs_pin_level(want_data, act_low);
    end
  end

  // R1: handshake off leaves RTS inactive
  p_rts_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en |=> (rts_pin == $past(act_low)));

  // R5: reaching the threshold withdraws RTS
  p_rts_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (CMP_W'(rx_level) >= CMP_W'(thr)) |=> !rts_asserted_q);

  // R6: a zero threshold keeps RTS withdrawn
  p_zero_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |=> (rts_pin == $past(act_low)));

endmodule

// File: rtl/fc_flush_ctrl.sv
module fc_flush_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tx_flush_set,
  input  logic rx_flush_set,
  output logic en_fall,
  output logic tx_flush,
  output logic rx_flush
);
  logic en_q;

  assign en_fall = en_q && !enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      tx_flush <= 1'b0;
      rx_flush <= 1'b0;
    end else begin
      en_q     <= enable;
      tx_flush <= tx_flush_set || en_fall;
      rx_flush <= rx_flush_set || en_fall;
    end
  end

  // R7: a flush write always yields its pulse
  p_tx_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_set |=> tx_flush);
  p_rx_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_set |=> rx_flush);

  // R8: turning the UART off flushes both FIFOs
  p_off_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> (tx_flush && rx_flush));

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
  parameter int FIFO_DEPTH  = 64,
  parameter int THR_W       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_hs_en,
  input  logic             cfg_act_low,
  input  logic [THR_W-1:0] cfg_rts_thr,
  input  logic             cfg_tx_flush_set,
  input  logic             cfg_rx_flush_set,
  input  logic             cts_pin,
  input  logic [LVL_W-1:0] tx_fifo_level,
  input  logic [LVL_W-1:0] rx_fifo_level,
  input  logic             tx_busy,
  input  logic             tx_done,
  output logic             rts_pin,
  output logic             tx_start,
  output logic             tx_flush,
  output logic             rx_flush
);
  // Named internal events, visible to assertions
  logic cts_active;
  logic tx_has_data;
  logic en_fall;

  assign tx_has_data = (tx_fifo_level != '0);

  fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_pin    (cts_pin),
    .act_low    (cfg_act_low),
    .cts_active (cts_active)
  );

  fc_tx_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .hs_en      (cfg_hs_en),
    .cts_active (cts_active),
    .has_data   (tx_has_data),
    .tx_busy    (tx_busy),
    .tx_done    (tx_done),
    .tx_start   (tx_start)
  );

  fc_rts_ctrl #(.LVL_W(LVL_W), .THR_W(THR_W)) u_rts (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (cfg_enable),
    .hs_en    (cfg_hs_en),
    .act_low  (cfg_act_low),
    .thr      (cfg_rts_thr),
    .rx_level (rx_fifo_level),
    .rts_pin  (rts_pin)
  );

  fc_flush_ctrl u_flush (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (cfg_enable),
    .tx_flush_set (cfg_tx_flush_set),
    .rx_flush_set (cfg_rx_flush_set),
    .en_fall      (en_fall),
    .tx_flush     (tx_flush),
    .rx_flush     (rx_flush)
  );

  // R3: an empty transmit FIFO never leads to a grant
  p_empty_no_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_has_data |=> !tx_start);

  // R8: while disabled, RTS is held inactive
  p_off_rts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (rts_pin == $past(cfg_act_low)));

endmodule

// File: tb/tb_uart_flow_ctrl.sv
module tb_uart_flow_ctrl;
  localparam int LVL_W = 7;
  localparam int THR_W = 6;
  localparam int FRAME = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_hs_en = 1'b0, cfg_act_low = 1'b0;
  logic [THR_W-1:0] cfg_rts_thr = '0;
  logic cfg_tx_flush_set = 1'b0, cfg_rx_flush_set = 1'b0;
  logic cts_pin = 1'b0;
  logic [LVL_W-1:0] tx_loaded = '0, tx_popped = '0, tx_fifo_level;
  logic [LVL_W-1:0] rx_fifo_level = '0;
  logic tx_busy = 1'b0, tx_done = 1'b0;
  logic rts_pin, tx_start, tx_flush, rx_flush;
  int   shift_cnt = 0;
  int   frames_done = 0;
  int   checks = 0, errors = 0;
  int   exp_q[$];

  always #5 clk = ~clk;

  assign tx_fifo_level = tx_loaded - tx_popped;

  uart_flow_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_hs_en(cfg_hs_en),
    .cfg_act_low(cfg_act_low), .cfg_rts_thr(cfg_rts_thr),
    .cfg_tx_flush_set(cfg_tx_flush_set), .cfg_rx_flush_set(cfg_rx_flush_set),
    .cts_pin(cts_pin), .tx_fifo_level(tx_fifo_level), .rx_fifo_level(rx_fifo_level),
    .tx_busy(tx_busy), .tx_done(tx_done), .rts_pin(rts_pin), .tx_start(tx_start),
    .tx_flush(tx_flush), .rx_flush(rx_flush)
  );

  // Shifter model: a granted character occupies FRAME cycles, then reports done.
  always @(posedge clk) begin
    tx_done <= 1'b0;
    if (tx_start) begin
      tx_busy   <= 1'b1;
      shift_cnt <= FRAME - 1;
      tx_popped <= tx_popped + 1'b1;
    end else if (tx_busy) begin
      if (shift_cnt == 0) begin
        tx_busy <= 1'b0;
        tx_done <= 1'b1;
      end else begin
        shift_cnt <= shift_cnt - 1;
      end
    end
  end

  // Monitor: every grant must match an item the driver queued.
  always @(negedge clk) begin
    if (rst_n && tx_start) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R4 unexpected grant: actual=1 expected=0 at %0t", $time);
      end else begin
        void'(exp_q.pop_front());
      end
    end
    if (rst_n && tx_done) frames_done++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_grants(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(i);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int t = 0;
    while ((exp_q.size() != 0 || tx_busy || tx_fifo_level != 0) && t < 400) begin
      @(negedge clk);
      t++;
    end
    cycles(3);
    chk(req, exp_q.size(), 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int base;
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rts", rts_pin, 0);
    chk("R3 reset start", tx_start, 0);
    chk("R7 reset txflush", tx_flush, 0);
    chk("R7 reset rxflush", rx_flush, 0);

    // R1: handshake off, CTS inactive, grants still flow; RTS inactive
    cfg_enable = 1'b1;
    cts_pin = 1'b0;
    rx_fifo_level = 7'd0;
    cfg_rts_thr = 6'd8;
    base = frames_done;
    expect_grants(2);
    tx_loaded = tx_loaded + 7'd2;
    drain("R1 grants with handshake off");
    chk("R3 two characters done", frames_done - base, 2);
    chk("R1 rts inactive while off", rts_pin, 0);

    // R5: threshold edges
    cfg_hs_en = 1'b1;
    rx_fifo_level = 7'd7; cycles(1);
    chk("R5 level thr-1 asserts", rts_pin, 1);
    rx_fifo_level = 7'd8; cycles(1);
    chk("R5 level thr withdraws", rts_pin, 0);
    rx_fifo_level = 7'd7; cycles(1);
    chk("R5 level back below", rts_pin, 1);
    cfg_rts_thr = 6'd63; rx_fifo_level = 7'd62; cycles(1);
    chk("R5 top thr minus one", rts_pin, 1);
    rx_fifo_level = 7'd63; cycles(1);
    chk("R5 top thr reached", rts_pin, 0);

    // R6: zero threshold
    cfg_rts_thr = 6'd0; rx_fifo_level = 7'd0; cycles(1);
    chk("R6 zero thr empty fifo", rts_pin, 0);

    // R2: active-low polarity on both pins
    cfg_act_low = 1'b1; cfg_rts_thr = 6'd8; rx_fifo_level = 7'd7; cycles(1);
    chk("R2 low asserted rts", rts_pin, 0);
    rx_fifo_level = 7'd8; cycles(1);
    chk("R2 low inactive rts", rts_pin, 1);
    cts_pin = 1'b1;
    cycles(3);
    tx_loaded = tx_loaded + 7'd1;
    cycles(20);
    chk("R2 cts high means not clear", tx_fifo_level, 1);
    expect_grants(1);
    cts_pin = 1'b0;
    drain("R2 cts low releases grant");

    // R4: CTS drops mid-character
    cfg_act_low = 1'b0;
    cts_pin = 1'b1;
    cycles(3);
    base = frames_done;
    expect_grants(1);
    tx_loaded = tx_loaded + 7'd3;
    while (!tx_busy) @(negedge clk);
    cycles(3);
    cts_pin = 1'b0;
    cycles(40);
    chk("R4 character completes", frames_done - base, 1);
    chk("R4 remaining held", tx_fifo_level, 2);
    expect_grants(2);
    cts_pin = 1'b1;
    drain("R4 resume after cts");
    chk("R4 all characters done", frames_done - base, 3);

    // R7: independent flush pulses
    cfg_tx_flush_set = 1'b1; @(negedge clk); cfg_tx_flush_set = 1'b0;
    chk("R7 tx flush pulse", tx_flush, 1);
    chk("R7 rx untouched", rx_flush, 0);
    @(negedge clk);
    chk("R7 tx flush clears", tx_flush, 0);
    cfg_rx_flush_set = 1'b1; @(negedge clk); cfg_rx_flush_set = 1'b0;
    chk("R7 rx flush pulse", rx_flush, 1);
    chk("R7 tx untouched", tx_flush, 0);
    @(negedge clk);
    chk("R7 rx flush clears", rx_flush, 0);

    // R8: disable flushes both, blocks grants, RTS inactive
    rx_fifo_level = 7'd0; cfg_rts_thr = 6'd8; cycles(1);
    chk("R8 rts asserted before off", rts_pin, 1);
    cfg_enable = 1'b0; @(negedge clk);
    chk("R8 off tx flush", tx_flush, 1);
    chk("R8 off rx flush", rx_flush, 1);
    chk("R8 off rts inactive", rts_pin, 0);
    @(negedge clk);
    chk("R8 flush single cycle", tx_flush + rx_flush, 0);
    tx_loaded = tx_loaded + 7'd1;
    cycles(20);
    chk("R8 no grant while off", tx_fifo_level, 1);

    summary();
  end
endmodule